// File: doc/BRIEF.md
# Serial-Bus Trim Code Controller

This block is a two-wire serial-bus target that owns the 7-bit code driving a trim DAC. The system clock oversamples the SCL and SDA lines, and the block decodes one-byte transactions addressed to it. It keeps two copies of the code. The live DAC register sets the output. The retained copy models a non-volatile cell, and programming it takes a fixed number of clocks. Each write carries the seven code bits, most significant first, and then a target-select bit. That bit chooses whether the live register is loaded or the retained copy is programmed. A read returns the live code.

On the bus, SDA is open-drain. The block only asserts `sda_pull_low`, and the surrounding pad logic combines that with the line. A write-enable input must be high for either target to accept data. While the retained copy is programming, `prog_busy` is high and the block refuses every write. Two resets are provided. `por_n` is the supply-level reset: it gives the retained copy its factory value 80H, which is code 64 with a select bit of 0. `rst_n` is the functional reset: when it is released, the live register is reloaded from the retained copy.

The controller is a single state machine. It has these states:

- LOAD: copies the retained code into the live register for one cycle after reset.
- IDLE: waits for a START.
- ADDR: collects the address byte.
- AACK: drives the address acknowledge.
- WBYTE: collects the write byte.
- WACK: drives the data acknowledge and commits the write.
- RBYTE: shifts out the read byte.
- SKIP: ignores the bus until the next START or STOP.

It has these transitions:

- LOAD to IDLE.
- Any state other than LOAD to ADDR on a START, including a repeated START.
- Any state other than LOAD to IDLE on a STOP.
- ADDR to AACK on an address match, or to SKIP otherwise.
- AACK to WBYTE for a write, or to RBYTE for a read.
- WBYTE to WACK when writes are enabled, or to SKIP otherwise.
- WACK to SKIP.
- RBYTE to SKIP.

Top module: `trim_code_i2c`

## Requirements
- R1: The block answers only the address 1001111, sent MSB first and followed by the R/W bit (1 = read). For any other address, SDA stays released through the ninth clock, and the code does not change.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either event abandons any transfer in progress, and a transfer cut short this way changes nothing. The block changes its SDA drive only while SCL is low.
- R3: A write whose data byte has its last bit (bit 0, the select bit) at 1 loads bits 7..1 into `dac_code`. Both the address and the data byte are acknowledged.
- R4: A write with a select bit of 0 programs bits 7..1 into the retained copy. `prog_busy` stays high for PROG_CYCLES clocks, and `dac_code` does not change.
- R5: While `prog_busy` is high, a write address is not acknowledged and nothing changes. A read is still acknowledged and served.
- R6: After the address acknowledge, a read shifts out `dac_code` MSB first in clocks 1 to 7. SDA is released in clock 8, so the byte reads as {code, 1}.
- R7: With `wp_in` low, a write address is acknowledged but the data byte is not. Neither the live register nor the retained copy changes.
- R8: After `por_n`, the retained copy holds 80H. After `rst_n` is released, `dac_code` equals bits 7..1 of the retained copy: 64 at first, and later the last programmed code.
- R9: A pulse on SCL or SDA shorter than FILT_CYCLES system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| por_n | input | 1 | Supply-level reset, active low; gives the retained copy its factory value |
| rst_n | input | 1 | Functional reset, active low; the live code reloads when it is released |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received |
| wp_in | input | 1 | Write enable, high to allow writes; the pad pulls it low |
| sda_pull_low | output | 1 | Open-drain drive: 1 pulls SDA low |
| dac_code | output | 7 | Live trim code |
| prog_busy | output | 1 | Retained copy is being programmed |

## Verification
The bench sweeps the code space through write-then-read pairs. A mixed-up select bit, a reversed shift order or an off-by-one bit count shows up there as a wrong code or a missing acknowledge. It sends every single-bit variant of the address. A comparator that ignored one bit would then acknowledge a stranger. It cuts writes short with a STOP and with a repeated START. A block that committed a partial byte would alter the code, and one that missed the repeated START would return no read data. It also probes the busy window and the write-enable input: a block that ignored busy would take the write, and one that ignored the write enable would change the code. It reloads after reset, which catches a live register that powers up at zero, and it injects short pulses on SCL and SDA. A weak filter would count an extra bit or see a false START.

// File: rtl/trimcal_pkg.sv
package trimcal_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = BYTE_W - 1;

    typedef enum logic [2:0] {
        ST_LOAD, ST_IDLE, ST_ADDR, ST_AACK,
        ST_WBYTE, ST_WACK, ST_RBYTE, ST_SKIP
    } ctl_state_t;
endpackage

// File: rtl/bus_filter.sv
module bus_filter #(
    parameter int   FILT_CYCLES = 12,
    parameter logic IDLE_VAL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(FILT_CYCLES + 1);

    logic          s1_q, s2_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= IDLE_VAL;
            s2_q  <= IDLE_VAL;
            filt  <= IDLE_VAL;
            run_q <= '0;
        end else begin
            s1_q <= raw;
            s2_q <= s1_q;
            if (s2_q == filt) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_CYCLES - 1)) begin
                filt  <= s2_q;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // The filtered level only ever takes a value the synchroniser held.
    assert_filter_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt) |-> (filt == $past(s2_q)));
endmodule

// File: rtl/nv_cell.sv
module nv_cell #(
    parameter int                DATA_W      = 7,
    parameter logic [DATA_W-1:0] INIT        = '0,
    parameter int                PROG_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              prog_req,
    input  logic [DATA_W-1:0] prog_data,
    output logic [DATA_W-1:0] stored,
    output logic              busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [DATA_W-1:0] pend_q;
    logic [CW-1:0]     cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            stored <= INIT;
            pend_q <= '0;
            busy   <= 1'b0;
            cnt_q  <= '0;
        end else if (busy) begin
            if (cnt_q == CW'(PROG_CYCLES - 1)) begin
                stored <= pend_q;
                busy   <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (prog_req) begin
            pend_q <= prog_data;
            busy   <= 1'b1;
            cnt_q  <= '0;
        end
    end

    assert_prog_starts_R4: assert property (@(posedge clk) disable iff (!por_n)
        (prog_req && !busy) |=> busy);
    assert_store_idle_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
        !busy |=> $stable(stored));
endmodule

// File: rtl/trim_code_i2c.sv
module trim_code_i2c
    import trimcal_pkg::*;
#(
    parameter logic [6:0]        SLAVE_ADDR  = 7'b1001111,
    parameter logic [BYTE_W-1:0] NV_INIT     = 8'h80,
    parameter int                FILT_CYCLES = 12,
    parameter int                PROG_CYCLES = 20_000_000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              wp_in,
    output logic              sda_pull_low,
    output logic [CODE_W-1:0] dac_code,
    output logic              prog_busy
);
    localparam int         BCW   = $clog2(BYTE_W + 1);
    localparam int         NLINE = 3;
    localparam logic [2:0] IDLE  = 3'b011;   // wp idles low, bus lines high

    // Input conditioning: scl, sda, write enable
    logic [NLINE-1:0] raw_v, filt_v;
    assign raw_v = {wp_in, sda_in, scl_in};

    for (genvar i = 0; i < NLINE; i++) begin : g_line
        bus_filter #(.FILT_CYCLES(FILT_CYCLES), .IDLE_VAL(IDLE[i])) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_v[i]),
            .filt (filt_v[i])
        );
    end

    logic scl_f, sda_f, wp_f, scl_p, sda_p;
    assign scl_f = filt_v[0];
    assign sda_f = filt_v[1];
    assign wp_f  = filt_v[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    logic scl_rise, scl_fall, start_ev, stop_ev;
    assign scl_rise = scl_f & ~scl_p;
    assign scl_fall = ~scl_f & scl_p;
    assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
    assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;

    // Retained copy
    logic              prog_req, nv_busy;
    logic [CODE_W-1:0] nv_code;
    logic [BYTE_W-1:0] shreg_q, shreg_d;

    nv_cell #(
        .DATA_W     (CODE_W),
        .INIT       (NV_INIT[BYTE_W-1:1]),
        .PROG_CYCLES(PROG_CYCLES)
    ) u_nv (
        .clk      (clk),
        .por_n    (por_n),
        .prog_req (prog_req),
        .prog_data(shreg_q[BYTE_W-1:1]),
        .stored   (nv_code),
        .busy     (nv_busy)
    );

    // Controller
    ctl_state_t        st_q, st_d;
    logic [BCW-1:0]    bcnt_q, bcnt_d;
    logic              rw_q, rw_d, sda_low_q, sda_low_d;
    logic [CODE_W-1:0] dac_q, dac_d;
    logic              addr_hit, bits_done;

    assign addr_hit  = (shreg_q[BYTE_W-1:1] == SLAVE_ADDR);
    assign bits_done = (bcnt_q == BCW'(BYTE_W));

    always_comb begin
        st_d      = st_q;
        shreg_d   = shreg_q;
        bcnt_d    = bcnt_q;
        rw_d      = rw_q;
        sda_low_d = sda_low_q;
        dac_d     = dac_q;
        prog_req  = 1'b0;
        if (st_q == ST_LOAD) begin
            dac_d = nv_code;
            st_d  = ST_IDLE;
        end else if (start_ev) begin
            st_d      = ST_ADDR;
            bcnt_d    = '0;
            sda_low_d = 1'b0;
        end else if (stop_ev) begin
            st_d      = ST_IDLE;
            sda_low_d = 1'b0;
        end else begin
            unique case (st_q)
                ST_LOAD, ST_IDLE, ST_SKIP: ;
                ST_ADDR, ST_WBYTE: begin
                    if (scl_rise && !bits_done) begin
                        shreg_d = {shreg_q[BYTE_W-2:0], sda_f};
                        bcnt_d  = bcnt_q + 1'b1;
                    end else if (scl_fall && bits_done) begin
                        if (st_q == ST_ADDR) begin
                            if (addr_hit && (shreg_q[0] || !nv_busy)) begin
                                sda_low_d = 1'b1;
                                rw_d      = shreg_q[0];
                                st_d      = ST_AACK;
                            end else begin
                                st_d = ST_SKIP;
                            end
                        end else if (wp_f) begin
                            sda_low_d = 1'b1;
                            st_d      = ST_WACK;
                            if (shreg_q[0]) dac_d = shreg_q[BYTE_W-1:1];
                            else            prog_req = 1'b1;
                        end else begin
                            st_d = ST_SKIP;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        bcnt_d = '0;
                        if (rw_q) begin
                            shreg_d   = {dac_q, 1'b1};
                            sda_low_d = ~dac_q[CODE_W-1];
                            st_d      = ST_RBYTE;
                        end else begin
                            sda_low_d = 1'b0;
                            st_d      = ST_WBYTE;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        sda_low_d = 1'b0;
                        st_d      = ST_SKIP;
                    end
                end
                ST_RBYTE: begin
                    if (scl_rise) begin
                        bcnt_d = bcnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (bits_done) begin
                            sda_low_d = 1'b0;
                            st_d      = ST_SKIP;
                        end else begin
                            shreg_d   = {shreg_q[BYTE_W-2:0], 1'b1};
                            sda_low_d = ~shreg_q[BYTE_W-2];
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_LOAD;
            shreg_q   <= '0;
            bcnt_q    <= '0;
            rw_q      <= 1'b0;
            sda_low_q <= 1'b0;
            dac_q     <= '0;
        end else begin
            st_q      <= st_d;
            shreg_q   <= shreg_d;
            bcnt_q    <= bcnt_d;
            rw_q      <= rw_d;
            sda_low_q <= sda_low_d;
            dac_q     <= dac_d;
        end
    end

    always_comb begin
        sda_pull_low = sda_low_q;
        dac_code     = dac_q;
        prog_busy    = nv_busy;
    end

    assert_ack_only_own_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_AACK) |-> (shreg_q[BYTE_W-1:1] == SLAVE_ADDR));
    assert_sda_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low_q) |-> !scl_f);
    assert_no_write_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_AACK && !rw_q) |-> !nv_busy);
    assert_protected_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_f && st_q != ST_LOAD) |=> $stable(dac_q));
endmodule

// File: tb/sim_trim_code_i2c.sv
module sim_trim_code_i2c;
    localparam int         Q     = 20;
    localparam int         FILT  = 4;
    localparam int         PROG  = 4000;
    localparam logic [6:0] ADDR  = 7'b1001111;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b1;
    logic sda_pull_low, prog_busy, sda_bus;
    logic [6:0] dac_code;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_pull_low;

    trim_code_i2c #(.FILT_CYCLES(FILT), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .wp_in(wp), .sda_pull_low(sda_pull_low), .dac_code(dac_code), .prog_busy(prog_busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        sda_m = b; wq();
        if (glitch) begin   // short SCL pulse while low, short SDA flip while high
            scl_m = 1'b1; repeat (FILT - 1) @(negedge clk); scl_m = 1'b0;
        end
        wq(); scl_m = 1'b1; wq();
        if (glitch) begin
            sda_m = ~b; repeat (FILT - 1) @(negedge clk); sda_m = b;
        end
        wq(); scl_m = 1'b0;
    endtask

    task automatic recv_bit(output logic r);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); r = sda_bus; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, input bit glitch, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i], glitch);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic write_txn(input logic [6:0] code, input logic p, input bit glitch,
                             output bit aack, output bit dack);
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b0, aack);
        dack = 1'b0;
        if (aack) send_byte({code, p}, glitch, dack);
        bus_stop();
    endtask

    task automatic read_body(output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin recv_bit(r); d[i] = r; end
        send_bit(1'b0, 1'b0);
    endtask

    task automatic read_txn(output bit aack, output logic [7:0] d);
        bus_start();
        send_byte({ADDR, 1'b1}, 1'b0, aack);
        d = 8'h00;
        if (aack) read_body(d);
        bus_stop();
    endtask

    task automatic wait_idle_prog();
        for (int i = 0; i < 3 * PROG && prog_busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit aa, da;
        logic [7:0] rd;
        logic [6:0] code, keep;
        repeat (10) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        repeat (50) @(negedge clk);

        // R8: factory value 80H loads as code 64
        check(dac_code == 7'd64, "R8 reset code", dac_code, 64);
        check(!prog_busy && !sda_pull_low, "R8 reset outputs", {prog_busy, sda_pull_low}, 0);
        read_txn(aa, rd);
        check(aa && rd == 8'h81, "R6 read after reset", rd, 8'h81);

        // R3/R6 sweep over the code space
        for (int c = 0; c <= 26; c++) begin
            code = (c * 5 > 127) ? 7'd127 : 7'(c * 5);
            write_txn(code, 1'b1, 1'b0, aa, da);
            check(aa && da, "R3 write acks", {aa, da}, 3);
            check(dac_code == code, "R3 code loaded", dac_code, code);
            read_txn(aa, rd);
            check(aa && rd == {code, 1'b1}, "R6 read back", rd, {code, 1'b1});
        end

        // R1: every single-bit address error, plus all-zero
        keep = dac_code;
        for (int b = 0; b <= 7; b++) begin
            logic [6:0] bad;
            bad = (b == 7) ? 7'd0 : (ADDR ^ (7'd1 << b));
            bus_start();
            send_byte({bad, 1'b0}, 1'b0, aa);
            if (!aa) send_byte(8'h23, 1'b0, da);
            bus_stop();
            check(!aa, "R1 foreign address nacked", aa, 0);
            check(dac_code == keep, "R1 code untouched", dac_code, keep);
        end

        // R7: write protect
        wp = 1'b0; repeat (20) @(negedge clk);
        write_txn(7'h33, 1'b1, 1'b0, aa, da);
        check(aa && !da, "R7 addr ack data nack", {aa, da}, 2);
        check(dac_code == keep, "R7 live code held", dac_code, keep);
        write_txn(7'h33, 1'b0, 1'b0, aa, da);
        check(!da && !prog_busy, "R7 no programming", {da, prog_busy}, 0);
        wp = 1'b1; repeat (20) @(negedge clk);

        // R4: program the retained copy
        write_txn(7'h23, 1'b0, 1'b0, aa, da);
        check(aa && da && prog_busy, "R4 program accepted", {aa, da, prog_busy}, 7);
        check(dac_code == keep, "R4 live code held", dac_code, keep);

        // R5: busy window
        write_txn(7'h10, 1'b1, 1'b0, aa, da);
        check(!aa && dac_code == keep, "R5 write refused while busy", {aa, dac_code}, {1'b0, keep});
        read_txn(aa, rd);
        check(aa && rd == {keep, 1'b1}, "R5 read while busy", rd, {keep, 1'b1});
        check(prog_busy, "R4 still busy", prog_busy, 1);
        wait_idle_prog();
        check(!prog_busy && dac_code == keep, "R4 done, live code held", {prog_busy, dac_code}, {1'b0, keep});
        write_txn(7'h11, 1'b1, 1'b0, aa, da);
        check(aa && da && dac_code == 7'h11, "R5 write after busy", dac_code, 7'h11);

        // R8: functional reset reloads the programmed copy
        rst_n = 1'b0; repeat (5) @(negedge clk); rst_n = 1'b1; repeat (50) @(negedge clk);
        check(dac_code == 7'h23, "R8 reload programmed copy", dac_code, 7'h23);

        // R2: STOP mid-byte abandons the write
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b0, aa);
        send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
        bus_stop();
        check(aa && dac_code == 7'h23, "R2 stop aborts", dac_code, 7'h23);

        // R2: repeated START mid-byte, then a read
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b0, aa);
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
        bus_start();
        send_byte({ADDR, 1'b1}, 1'b0, aa);
        rd = 8'h00;
        if (aa) read_body(rd);
        bus_stop();
        check(aa && rd == {7'h23, 1'b1}, "R2 repeated start read", rd, {7'h23, 1'b1});
        check(dac_code == 7'h23, "R2 repeated start no commit", dac_code, 7'h23);

        // R9: glitches on SCL and SDA
        write_txn(7'h5A, 1'b1, 1'b1, aa, da);
        check(aa && da && dac_code == 7'h5A, "R9 glitches ignored", dac_code, 7'h5A);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule